// File: doc/BRIEF.md
# Shared Converter Access Arbiter

This block decides which of three requesters may use one shared analog-to-digital converter. Requester 0 is a low-power controller, requester 1 is a digital scan controller and requester 2 is a radio power-detect controller. Each requester raises a request line. The arbiter answers with a registered one-hot grant. The grant holds until the converter signals that its conversion is done.

A small configuration register holds the arbitration mode and a priority for each requester. It loads on a single write strobe. Three modes are available: shielded, fixed priority and round-robin.

When a conversion finishes, the result is broadcast to all three requesters. Only the requester that owned the conversion receives the real channel code. Every other requester receives the all-ones channel code, which lies above any valid channel index, and its invalid flag is raised. A requester that lost arbitration can therefore discard the sample.

Top module: `adcArbiter`

## Requirements
- R1: After reset, `grantOut` is 0 and `resStrobe` is 0. The configuration resets to fixed-priority mode with priorities 1, 0 and 2 for requesters 0, 1 and 2, so the radio requester wins when all three request.
- R2: `grantOut` is always zero or one-hot. With no grant held and no request pending, `grantOut` stays 0 on the next cycle.
- R3: With no grant held, a request seen at a clock edge produces the grant on that edge. The grant then stays unchanged, whatever happens to the requests, until an edge on which `convDone` is high. That edge clears the grant to 0. A new grant can appear no earlier than the following edge.
- R4: In fixed mode (code 1, and reserved code 3), the pending requester with the numerically highest priority wins. Ties go to the lowest requester index.
- R5: In shield mode (code 0), only the requester with the highest configured priority can be granted, whether or not the others request. Ties go to the lowest index. All other requesters are never granted in this mode.
- R6: In round-robin mode (code 2), priorities are ignored. The search starts one index past the last requester whose conversion completed, wrapping from 2 to 0, and starts at 0 after reset. The first pending requester found wins.
- R7: A `cfgWr` pulse loads `cfgMode` and `cfgPrio` at the clock edge. Requester i's priority is `cfgPrio[2i+1:2i]`. The new values govern arbitrations from the next edge on, and the write does not disturb a grant already held.
- R8: On the cycle after `convDone`, `resStrobe` is 1 and `resData` equals the sampled data. For requester i the channel field is `resChanOut[4i+3:4i]`. The owner's field equals `resChanIn` with `resInvalid[i]` = 0. Every non-owner's field is 4'hF with `resInvalid[i]` = 1. A `convDone` with no grant held marks all three invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Load mode and priorities |
| cfgMode | input | 2 | Mode: 0 shield, 1 fixed, 2 round-robin, 3 as fixed |
| cfgPrio | input | 6 | Packed priorities, 2 bits per requester |
| reqIn | input | 3 | Request lines, bit i from requester i |
| convDone | input | 1 | Conversion complete strobe |
| resChanIn | input | 4 | Channel of the finished conversion |
| resDataIn | input | 12 | Data of the finished conversion |
| grantOut | output | 3 | One-hot grant |
| resStrobe | output | 1 | Result fields updated this cycle |
| resData | output | 12 | Broadcast result data |
| resChanOut | output | 12 | Per-requester channel code, 4 bits each |
| resInvalid | output | 3 | Per-requester invalid flag |

## Verification
A wrong busy flag or a lost grant register shows up on `grantOut` within one cycle. It appears either as a grant that changes before `convDone` or as a grant that survives it. A corrupted round-robin pointer or configuration register stays hidden until the next arbitration with more than one pending requester. At that arbitration, the wrong requester appears on `grantOut` one edge after the request. Ownership errors reach the requesters on the cycle after `convDone`, as a valid channel code handed to the wrong index. The reference model is compared on every clock, so each of these shows up at the first cycle where the ports diverge.

// File: rtl/adcArbPkg.sv
`timescale 1ns/1ps
package adcArbPkg;

  typedef enum logic [1:0] {
    MODE_SHIELD = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_ROUND  = 2'd2,
    MODE_RSVD   = 2'd3
  } arbMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
    logic captureResult;
  } arbStrb_t;

endpackage

// File: rtl/adcArbCtrl.sv
`timescale 1ns/1ps
module adcArbCtrl
  import adcArbPkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int PRIO_W  = 2,
  parameter logic [1:0] RST_MODE = 2'd1,
  parameter logic [NUM_REQ*PRIO_W-1:0] RST_PRIO = '0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWr,
  input  logic [1:0]                cfgMode,
  input  logic [NUM_REQ*PRIO_W-1:0] cfgPrio,
  input  logic [NUM_REQ-1:0]        reqIn,
  input  logic                      convDone,
  input  logic [NUM_REQ-1:0]        grantQ,
  output arbStrb_t                  strb,
  output logic [NUM_REQ-1:0]        nextGrant
);

  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  arbMode_e                  modeQ;
  logic [NUM_REQ*PRIO_W-1:0] prioQ;
  logic                      busyQ;
  logic [IDX_W-1:0]          rrPtrQ;

  logic [PRIO_W-1:0] prioArr [NUM_REQ];
  logic [IDX_W-1:0]  topIdx, fixIdx, rrIdx, winIdx, ownIdx;
  logic              fixHit, rrHit, winHit;

  function automatic logic [IDX_W-1:0] wrapAdd(input logic [IDX_W-1:0] base, input int step);
    int sum;
    sum = int'(base) + step;
    if (sum >= NUM_REQ) sum = sum - NUM_REQ;
    return IDX_W'(sum);
  endfunction

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : gPrio
      assign prioArr[g]   = prioQ[g*PRIO_W +: PRIO_W];
      assign nextGrant[g] = winHit && (winIdx == IDX_W'(g));
    end
  endgenerate

  // Highest configured priority, lowest index on ties
  always_comb begin
    topIdx = '0;
    for (int i = 1; i < NUM_REQ; i++)
      if (prioArr[i] > prioArr[topIdx]) topIdx = IDX_W'(i);
  end

  // Fixed priority among pending requesters
  always_comb begin
    fixHit = 1'b0;
    fixIdx = '0;
    for (int i = 0; i < NUM_REQ; i++)
      if (reqIn[i] && (!fixHit || prioArr[i] > prioArr[fixIdx])) begin
        fixHit = 1'b1;
        fixIdx = IDX_W'(i);
      end
  end

  // Round-robin search from the pointer
  always_comb begin
    rrHit = 1'b0;
    rrIdx = '0;
    for (int k = 0; k < NUM_REQ; k++)
      if (!rrHit && reqIn[wrapAdd(rrPtrQ, k)]) begin
        rrHit = 1'b1;
        rrIdx = wrapAdd(rrPtrQ, k);
      end
  end

  always_comb begin
    unique case (modeQ)
      MODE_SHIELD: begin winHit = reqIn[topIdx]; winIdx = topIdx; end
      MODE_ROUND:  begin winHit = rrHit;         winIdx = rrIdx;  end
      default:     begin winHit = fixHit;        winIdx = fixIdx; end
    endcase
  end

  always_comb begin
    ownIdx = '0;
    for (int i = 0; i < NUM_REQ; i++)
      if (grantQ[i]) ownIdx = IDX_W'(i);
  end

  assign strb.loadGrant     = !busyQ && winHit;
  assign strb.clearGrant    = busyQ && convDone;
  assign strb.captureResult = convDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= arbMode_e'(RST_MODE);
      prioQ  <= RST_PRIO;
      busyQ  <= 1'b0;
      rrPtrQ <= '0;
    end else begin
      if (cfgWr) begin
        modeQ <= arbMode_e'(cfgMode);
        prioQ <= cfgPrio;
      end
      if (strb.loadGrant)       busyQ <= 1'b1;
      else if (strb.clearGrant) busyQ <= 1'b0;
      if (strb.clearGrant) rrPtrQ <= wrapAdd(ownIdx, 1);
    end
  end

endmodule

// File: rtl/adcArbData.sv
`timescale 1ns/1ps
module adcArbData
  import adcArbPkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int CHAN_W  = 4,
  parameter int DATA_W  = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  arbStrb_t                  strb,
  input  logic [NUM_REQ-1:0]        nextGrant,
  input  logic [CHAN_W-1:0]         resChanIn,
  input  logic [DATA_W-1:0]         resDataIn,
  output logic [NUM_REQ-1:0]        grantQ,
  output logic                      resStrobe,
  output logic [DATA_W-1:0]         resData,
  output logic [NUM_REQ*CHAN_W-1:0] resChanOut,
  output logic [NUM_REQ-1:0]        resInvalid
);

  localparam logic [CHAN_W-1:0] BAD_CHAN = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ    <= '0;
      resStrobe <= 1'b0;
      resData   <= '0;
    end else begin
      if (strb.clearGrant)     grantQ <= '0;
      else if (strb.loadGrant) grantQ <= nextGrant;
      resStrobe <= strb.captureResult;
      if (strb.captureResult) resData <= resDataIn;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : gTag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          resChanOut[g*CHAN_W +: CHAN_W] <= BAD_CHAN;
          resInvalid[g]                  <= 1'b0;
        end else if (strb.captureResult) begin
          resChanOut[g*CHAN_W +: CHAN_W] <= grantQ[g] ? resChanIn : BAD_CHAN;
          resInvalid[g]                  <= !grantQ[g];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/adcArbiter.sv
`timescale 1ns/1ps
module adcArbiter
  import adcArbPkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int PRIO_W  = 2,
  parameter int CHAN_W  = 4,
  parameter int DATA_W  = 12,
  parameter logic [1:0] RST_MODE = 2'd1,
  parameter logic [NUM_REQ*PRIO_W-1:0] RST_PRIO = 6'b10_00_01
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWr,
  input  logic [1:0]                cfgMode,
  input  logic [NUM_REQ*PRIO_W-1:0] cfgPrio,
  input  logic [NUM_REQ-1:0]        reqIn,
  input  logic                      convDone,
  input  logic [CHAN_W-1:0]         resChanIn,
  input  logic [DATA_W-1:0]         resDataIn,
  output logic [NUM_REQ-1:0]        grantOut,
  output logic                      resStrobe,
  output logic [DATA_W-1:0]         resData,
  output logic [NUM_REQ*CHAN_W-1:0] resChanOut,
  output logic [NUM_REQ-1:0]        resInvalid
);

  arbStrb_t           strb;
  logic [NUM_REQ-1:0] nextGrant;
  logic [NUM_REQ-1:0] grantQ;

  adcArbCtrl #(
    .NUM_REQ (NUM_REQ),
    .PRIO_W  (PRIO_W),
    .RST_MODE(RST_MODE),
    .RST_PRIO(RST_PRIO)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWr    (cfgWr),
    .cfgMode  (cfgMode),
    .cfgPrio  (cfgPrio),
    .reqIn    (reqIn),
    .convDone (convDone),
    .grantQ   (grantQ),
    .strb     (strb),
    .nextGrant(nextGrant)
  );

  adcArbData #(
    .NUM_REQ(NUM_REQ),
    .CHAN_W (CHAN_W),
    .DATA_W (DATA_W)
  ) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .nextGrant (nextGrant),
    .resChanIn (resChanIn),
    .resDataIn (resDataIn),
    .grantQ    (grantQ),
    .resStrobe (resStrobe),
    .resData   (resData),
    .resChanOut(resChanOut),
    .resInvalid(resInvalid)
  );

  assign grantOut = grantQ;

endmodule

// File: rtl/adcArbiterChk.sv
`timescale 1ns/1ps
module adcArbiterChk #(
  parameter int NUM_REQ = 3,
  parameter int CHAN_W  = 4,
  parameter int DATA_W  = 12
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_REQ-1:0]        reqIn,
  input logic                      convDone,
  input logic [CHAN_W-1:0]         resChanIn,
  input logic [NUM_REQ-1:0]        grantOut,
  input logic                      resStrobe,
  input logic [NUM_REQ*CHAN_W-1:0] resChanOut,
  input logic [NUM_REQ-1:0]        resInvalid
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(grantOut)); // R2
  AST_IDLE_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut == '0 && reqIn == '0) |=> grantOut == '0); // R2
  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut != '0 && $past(grantOut) == '0) |-> ($past(reqIn) & grantOut) != '0); // R3
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut != '0 && !convDone) |=> $stable(grantOut)); // R3
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut != '0 && convDone) |=> grantOut == '0); // R3
  AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> resStrobe); // R8
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && grantOut != '0) |=> $countones(resInvalid) == NUM_REQ - 1); // R8
  AST_NO_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && grantOut == '0) |=> resInvalid == '1); // R8

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : gOwn
      AST_OWNER_CHAN: assert property (@(posedge clk) disable iff (!rstN)
        (convDone && grantOut[g]) |=>
          (resChanOut[g*CHAN_W +: CHAN_W] == $past(resChanIn) && !resInvalid[g])); // R8
    end
  endgenerate

endmodule

bind adcArbiter adcArbiterChk #(
  .NUM_REQ(NUM_REQ),
  .CHAN_W (CHAN_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqIn     (reqIn),
  .convDone  (convDone),
  .resChanIn (resChanIn),
  .grantOut  (grantOut),
  .resStrobe (resStrobe),
  .resChanOut(resChanOut),
  .resInvalid(resInvalid)
);

// File: tb/adcArbiter_tb_top.sv
`timescale 1ns/1ps
module adcArbiter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic [5:0]  cfgPrio = 6'd0;
  logic [2:0]  reqIn = 3'd0;
  logic        convDone = 1'b0;
  logic [3:0]  resChanIn = 4'd0;
  logic [11:0] resDataIn = 12'd0;
  logic [2:0]  grantOut;
  logic        resStrobe;
  logic [11:0] resData;
  logic [11:0] resChanOut;
  logic [2:0]  resInvalid;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;
  string curTag = "R1";

  always #2.5 clk = ~clk;

  adcArbiter dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgPrio(cfgPrio),
    .reqIn(reqIn), .convDone(convDone), .resChanIn(resChanIn), .resDataIn(resDataIn),
    .grantOut(grantOut), .resStrobe(resStrobe), .resData(resData),
    .resChanOut(resChanOut), .resInvalid(resInvalid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int          mOwner, mMode, mRr;
  int          mPrio [3];
  bit          mStrobe;
  logic [11:0] mData, mChan;
  logic [2:0]  mInv;

  function automatic int pick();
    int top, best;
    if (mMode == 0) begin
      top = 0;
      for (int i = 1; i < 3; i++) if (mPrio[i] > mPrio[top]) top = i;
      return reqIn[top] ? top : -1;
    end
    if (mMode == 2) begin
      for (int k = 0; k < 3; k++) if (reqIn[(mRr + k) % 3]) return (mRr + k) % 3;
      return -1;
    end
    best = -1;
    for (int i = 0; i < 3; i++)
      if (reqIn[i] && (best < 0 || mPrio[i] > mPrio[best])) best = i;
    return best;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOwner = -1; mMode = 1; mRr = 0;
      mPrio[0] = 1; mPrio[1] = 0; mPrio[2] = 2;
      mStrobe = 0; mData = '0; mChan = '1; mInv = '0;
    end else begin
      mStrobe = convDone;
      if (convDone) begin
        mData = resDataIn;
        for (int i = 0; i < 3; i++) begin
          mChan[i*4 +: 4] = (mOwner == i) ? resChanIn : 4'hF;
          mInv[i]         = (mOwner != i);
        end
      end
      if (mOwner >= 0) begin
        if (convDone) begin mRr = (mOwner + 1) % 3; mOwner = -1; end
      end else begin
        mOwner = pick();
      end
      if (cfgWr) begin
        mMode = cfgMode;
        for (int i = 0; i < 3; i++) mPrio[i] = cfgPrio[i*2 +: 2];
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [2:0] eg;
      eg = (mOwner < 0) ? 3'b000 : 3'(1 << mOwner);
      chk(grantOut == eg, {curTag, " grant"}, 32'(grantOut), 32'(eg));
      chk(resStrobe == mStrobe && resData == mData && resChanOut == mChan && resInvalid == mInv,
          {curTag, " result"}, {resStrobe, 7'd0, resInvalid, 9'd0, resChanOut},
          {mStrobe, 7'd0, mInv, 9'd0, mChan});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input logic [1:0] m, input logic [5:0] p);
    cfgMode = m; cfgPrio = p; cfgWr = 1'b1;
    cyc(1);
    cfgWr = 1'b0;
  endtask

  task automatic finishConv(input logic [3:0] ch, input logic [11:0] d);
    convDone = 1'b1; resChanIn = ch; resDataIn = d;
    cyc(1);
    convDone = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [2:0] seen;
    cyc(3);
    chk(grantOut == 3'b000, "R1 reset grant", 32'(grantOut), 0);
    chk(resStrobe == 1'b0, "R1 reset strobe", 32'(resStrobe), 0);
    rstN = 1'b1;
    cyc(1);

    // Reset defaults: radio requester wins
    curTag = "R1";
    reqIn = 3'b111;
    cyc(1);
    chk(grantOut == 3'b100, "R1 default winner", 32'(grantOut), 32'(3'b100));
    reqIn = 3'b000;
    finishConv(4'd5, 12'h123);
    curTag = "R8";
    chk(resStrobe && resChanOut == 12'h5FF && resInvalid == 3'b011 && resData == 12'h123,
        "R8 owner tag", {20'd0, resChanOut}, 32'h5FF);
    chk(grantOut == 3'b000, "R3 release", 32'(grantOut), 0);

    // Default fixed: low-power (1) over digital (0)
    curTag = "R4";
    reqIn = 3'b011;
    cyc(1);
    chk(grantOut == 3'b001, "R4 fixed priority", 32'(grantOut), 1);
    reqIn = 3'b000;
    finishConv(4'd2, 12'h0AA);
    cyc(1);

    // Tie resolved by lowest index; reserved mode acts as fixed
    writeCfg(2'd3, 6'b01_01_01);
    reqIn = 3'b110;
    cyc(1);
    chk(grantOut == 3'b010, "R4 tie lowest index", 32'(grantOut), 2);

    // Hold while busy, config write does not disturb
    curTag = "R3";
    reqIn = 3'b000;
    cyc(2);
    chk(grantOut == 3'b010, "R3 held without request", 32'(grantOut), 2);
    curTag = "R7";
    writeCfg(2'd1, 6'b10_00_00);
    chk(grantOut == 3'b010, "R7 write during grant", 32'(grantOut), 2);
    finishConv(4'd7, 12'h777);
    chk(resChanOut == 12'hF7F && resInvalid == 3'b101, "R8 middle owner",
        {20'd0, resChanOut}, 32'hF7F);
    reqIn = 3'b011;
    cyc(1);
    chk(grantOut == 3'b001, "R7 new config applied", 32'(grantOut), 1);
    reqIn = 3'b000;
    finishConv(4'd1, 12'h001);
    cyc(1);

    // Shield: digital has top priority
    curTag = "R5";
    writeCfg(2'd0, 6'b01_10_00);
    reqIn = 3'b101;
    cyc(4);
    chk(grantOut == 3'b000, "R5 others blocked", 32'(grantOut), 0);
    reqIn = 3'b111;
    cyc(1);
    chk(grantOut == 3'b010, "R5 top served", 32'(grantOut), 2);
    reqIn = 3'b000;
    finishConv(4'd3, 12'h333);
    cyc(1);

    // Round-robin: three back-to-back owners differ
    curTag = "R6";
    writeCfg(2'd2, 6'b10_10_10);
    reqIn = 3'b111;
    seen = 3'b000;
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      seen = seen | grantOut;
      finishConv(4'(k), 12'(k));
    end
    chk(seen == 3'b111, "R6 rotation covers all", 32'(seen), 7);
    reqIn = 3'b000;
    cyc(1);

    // Done with no owner
    curTag = "R8";
    finishConv(4'd4, 12'h444);
    chk(resInvalid == 3'b111 && resChanOut == 12'hFFF, "R8 no owner", 32'(resInvalid), 7);
    chk(grantOut == 3'b000, "R2 idle zero", 32'(grantOut), 0);

    // Random mix checked against the model every cycle
    curTag = "R2";
    for (int n = 0; n < 4000; n++) begin
      reqIn     = 3'($urandom_range(0, 7));
      convDone  = ($urandom_range(0, 9) < 3);
      resChanIn = 4'($urandom_range(0, 9));
      resDataIn = 12'($urandom);
      cfgWr     = ($urandom_range(0, 19) == 0);
      cfgMode   = 2'($urandom_range(0, 3));
      cfgPrio   = {2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)), 2'($urandom_range(0, 2))};
      cyc(1);
    end
    reqIn = '0; convDone = 1'b0; cfgWr = 1'b0;
    cyc(2);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule